// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Claim/Complete Handshake

This block gathers up to 128 interrupt lines into one request towards a single processor. Each line has an enable bit, an 8-bit priority, an 8-bit routing byte and a 2-bit mode field. The line can be level-high or rising-edge triggered. Software programs the block through a small word-wide register port. Writes take effect at the clock edge. Reads return their data one cycle after the read strobe.

Among the enabled, pending lines whose priority beats the threshold, the block picks one winner. A lower priority value is more urgent, and on equal values the lower ID wins. Software claims the winner by reading the acknowledge register. The claimed line is then active. While a line is active the request output stays low. Writing that ID to the completion register ends the interrupt, and arbitration starts again.

The register space has two regions, picked by the top address bit. With the top bit at 1 it is the distribution region: control word at 0x000, enable-set words from 0x100, enable-clear words from 0x180, priority bytes from 0x400, routing bytes from 0x800 and mode fields from 0xC00. With the top bit at 0 it is the processor region: control at 0x000, threshold at 0x004, acknowledge at 0x00C and completion at 0x010.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request output is low. Every enable, priority, threshold and control register reads 0. A read of the acknowledge register returns 1023.
- R2: The request output can be high only when bit 0 of both control words (distribution 0x1000 and processor 0x0000) is 1. Writing 0 to bit 0 of either word drops the request in the next cycle.
- R3: Writing a 1 to bit N%32 of word 0x1100+(N/32)*4 enables line N. Writing a 1 to the same bit of word 0x1180+(N/32)*4 disables it. Zero bits have no effect, and a read of either word returns the current enable bits.
- R4: The priority of line N is byte N%4 (bits 8*(N%4)+7..8*(N%4)) of word 0x1400+(N/4)*4. A line can take part in arbitration only when its priority is strictly less than the threshold in bits 7:0 of 0x0004.
- R5: Among the eligible lines, the one with the lowest priority value wins. Ties go to the lowest ID.
- R6: A read strobe at 0x000C returns the winning ID in bits 9:0 of the read data in the next cycle. When the request output is low, the read returns 1023 and changes no state.
- R7: A claim makes the line active, and the request stays low from the next cycle on. A completion write (0x0010) carrying a different ID is ignored. A completion write carrying the active ID releases it.
- R8: A level line (mode bit 1 = 0) is pending while its input is high. The request follows the input one clock edge after the input changes.
- R9: An edge line (mode bit 1 = 1) latches pending on a 0-to-1 input transition. It stays pending after the input falls, and a claim clears it.
- R10: The routing byte of line N sits at byte N%4 of word 0x1800+(N/4)*4. The 2-bit mode field of line N sits at bits 2*(N%16)+1..2*(N%16) of word 0x1C00+(N/16)*4. Both read back as written. Routing bytes and mode bit 0 have no effect on arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | One interrupt line per source |
| bus_addr | input | ADDR_W | Byte address; top bit selects distribution region |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (acknowledge read has side effects) |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
A corrupted enable, priority or pending bit appears as the wrong ID on the next acknowledge read, or as a request that is present or missing one edge after the line changes. A stuck active flag keeps the request low after a correct completion write, and a lost one lets the request rise in the cycle right after a claim. Both are visible at the port the next cycle. Edge latches that fail to clear show up as a second claim of the same ID after its completion.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int          ID_W        = 10;
   localparam logic [9:0]  SPURIOUS_ID = 10'd1023;

   typedef enum logic { TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1 } trig_e;

   // distribution region offsets
   localparam logic [11:0] D_CTL  = 12'h000;
   localparam logic [4:0]  D_SET  = 5'b00010;  // 0x100..0x17F
   localparam logic [4:0]  D_CLR  = 5'b00011;  // 0x180..0x1FF
   localparam logic [1:0]  D_PRI  = 2'b01;     // 0x400..0x7FF
   localparam logic [1:0]  D_RTE  = 2'b10;     // 0x800..0xBFF
   localparam logic [1:0]  D_MODE = 2'b11;     // 0xC00..0xFFF

   // processor region offsets
   localparam logic [11:0] C_CTL  = 12'h000;
   localparam logic [11:0] C_THR  = 12'h004;
   localparam logic [11:0] C_ACK  = 12'h00C;
   localparam logic [11:0] C_DONE = 12'h010;
endpackage

// File: rtl/irqc_src_slice.sv
module irqc_src_slice
   import irqc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  trig_e mode,
   input  logic claim,
   output logic pend
);
   logic line_q;
   logic latched_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q    <= 1'b0;
         latched_q <= 1'b0;
      end else begin
         line_q <= line_in;
         if (mode == TRIG_LEVEL)
            latched_q <= 1'b0;
         else if (line_in && !line_q)
            latched_q <= 1'b1;
         else if (claim)
            latched_q <= 1'b0;
      end
   end

   assign pend = (mode == TRIG_EDGE) ? latched_q : line_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int NUM_SRC = 128,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = 10
) (
   input  logic [NUM_SRC-1:0]             cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]              thresh,
   output logic                           hit,
   output logic [ID_W-1:0]                win_id
);
   logic [PRIO_W-1:0] best;

   // Scan upward with strict compare: threshold is the starting bar,
   // equal priorities keep the earlier (lower) ID.
   always_comb begin
      best   = thresh;
      hit    = 1'b0;
      win_id = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cand[i] && (prio[i] < best)) begin
            best   = prio[i];
            hit    = 1'b1;
            win_id = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int PRIO_W  = 8,
   parameter int ADDR_W  = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_rd,
   output logic [31:0]        bus_rdata,
   output logic               irq_req
);
   localparam int EN_WORDS   = NUM_SRC / 32;
   localparam int BYTE_WORDS = NUM_SRC / 4;
   localparam int MODE_WORDS = NUM_SRC / 16;

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 256) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 between 32 and 256");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be 1..8");
   end
   if (ADDR_W != 13) begin : g_bad_addr
      $error("ADDR_W must be 13");
   end

   // ---------------- state ----------------
   logic                           dist_on, cpu_on;
   logic [PRIO_W-1:0]              thresh_q;
   logic [NUM_SRC-1:0]             en_q;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0][7:0]        route_q;
   logic [NUM_SRC-1:0][1:0]        mode_q;
   logic                           act_valid;
   logic [ID_W-1:0]                act_id;

   // ---------------- decode ----------------
   logic        in_dist;
   logic [11:0] ofs;
   logic [31:0] set_idx, grp_idx;
   logic        hit_set, hit_clr, hit_pri, hit_rte, hit_mode, hit_dctl;
   logic        hit_cctl, hit_thr, hit_ack, hit_done;

   assign in_dist  = bus_addr[ADDR_W-1];
   assign ofs      = bus_addr[11:0];
   assign set_idx  = 32'(ofs[6:2]);
   assign grp_idx  = 32'(ofs[9:2]);
   assign hit_dctl = in_dist && ofs == D_CTL;
   assign hit_set  = in_dist && ofs[11:7] == D_SET;
   assign hit_clr  = in_dist && ofs[11:7] == D_CLR;
   assign hit_pri  = in_dist && ofs[11:10] == D_PRI;
   assign hit_rte  = in_dist && ofs[11:10] == D_RTE;
   assign hit_mode = in_dist && ofs[11:10] == D_MODE;
   assign hit_cctl = !in_dist && ofs == C_CTL;
   assign hit_thr  = !in_dist && ofs == C_THR;
   assign hit_ack  = !in_dist && ofs == C_ACK;
   assign hit_done = !in_dist && ofs == C_DONE;

   // ---------------- per-source trigger logic ----------------
   logic [NUM_SRC-1:0] pend, claim;
   logic               any_hit, ack_take;
   logic [ID_W-1:0]    win_id;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irqc_src_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (src_in[g]),
         .mode    (trig_e'(mode_q[g][1])),
         .claim   (claim[g]),
         .pend    (pend[g])
      );
      assign claim[g] = ack_take && (win_id == ID_W'(g));
   end

   irqc_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .cand   (en_q & pend),
      .prio   (prio_q),
      .thresh (thresh_q),
      .hit    (any_hit),
      .win_id (win_id)
   );

   assign irq_req  = dist_on && cpu_on && !act_valid && any_hit;
   assign ack_take = bus_rd && hit_ack && irq_req;

   // ---------------- register writes ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dist_on   <= 1'b0;
         cpu_on    <= 1'b0;
         thresh_q  <= '0;
         en_q      <= '0;
         prio_q    <= '0;
         route_q   <= '0;
         mode_q    <= '0;
         act_valid <= 1'b0;
         act_id    <= '0;
      end else begin
         if (bus_wr && hit_dctl) dist_on  <= bus_wdata[0];
         if (bus_wr && hit_cctl) cpu_on   <= bus_wdata[0];
         if (bus_wr && hit_thr)  thresh_q <= bus_wdata[PRIO_W-1:0];
         for (int n = 0; n < NUM_SRC; n++) begin
            if (bus_wr && hit_set && set_idx == n / 32 && bus_wdata[n % 32]) en_q[n] <= 1'b1;
            if (bus_wr && hit_clr && set_idx == n / 32 && bus_wdata[n % 32]) en_q[n] <= 1'b0;
            if (bus_wr && hit_pri && grp_idx == n / 4)
               prio_q[n] <= bus_wdata[(n % 4) * 8 +: PRIO_W];
            if (bus_wr && hit_rte && grp_idx == n / 4)
               route_q[n] <= bus_wdata[(n % 4) * 8 +: 8];
            if (bus_wr && hit_mode && grp_idx == n / 16)
               mode_q[n] <= bus_wdata[(n % 16) * 2 +: 2];
         end
         if (ack_take) begin
            act_valid <= 1'b1;
            act_id    <= win_id;
         end else if (bus_wr && hit_done && act_valid && bus_wdata[ID_W-1:0] == act_id) begin
            act_valid <= 1'b0;
         end
      end
   end

   // ---------------- read path ----------------
   logic [31:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (hit_dctl) rd_val[0] = dist_on;
      if (hit_cctl) rd_val[0] = cpu_on;
      if (hit_thr)  rd_val[7:0] = 8'(thresh_q);
      if (hit_ack)  rd_val[ID_W-1:0] = irq_req ? win_id : SPURIOUS_ID;
      for (int n = 0; n < NUM_SRC; n++) begin
         if ((hit_set || hit_clr) && set_idx == n / 32) rd_val[n % 32] = en_q[n];
         if (hit_pri && grp_idx == n / 4)  rd_val[(n % 4) * 8 +: 8] = 8'(prio_q[n]);
         if (hit_rte && grp_idx == n / 4)  rd_val[(n % 4) * 8 +: 8] = route_q[n];
         if (hit_mode && grp_idx == n / 16) rd_val[(n % 16) * 2 +: 2] = mode_q[n];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_SRC = 128,
   parameter int ADDR_W  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              irq_req
);
   logic ack_rd, dctl_off, cctl_off;
   assign ack_rd   = bus_rd && bus_addr == ADDR_W'(13'h000C);
   assign dctl_off = bus_wr && bus_addr == ADDR_W'(13'h1000) && !bus_wdata[0];
   assign cctl_off = bus_wr && bus_addr == ADDR_W'(13'h0000) && !bus_wdata[0];

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_req);

   assert_dist_off_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dctl_off |=> !irq_req);

   assert_cpu_off_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cctl_off |=> !irq_req);

   assert_claim_valid_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && irq_req) |=> (bus_rdata < 32'(NUM_SRC)));

   assert_spurious_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !irq_req) |=> (bus_rdata == 32'd1023));

   assert_claim_masks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && irq_req) |=> !irq_req);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq_req   (irq_req)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int NSRC = 128;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_in = '0;
   logic [12:0]     bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic            bus_rd = 1'b0;
   logic [31:0]     bus_rdata;
   logic            irq_req;

   int n_run = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .irq_req(irq_req)
   );

   typedef struct packed {
      logic [NSRC-1:0] lines;
      logic [31:0]     exp_id;
   } vec_t;

   // priorities: all 0x80 except 5,70 = 0x40, 100 = 0x10, 127 = 0xA0; threshold 0x90
   localparam vec_t VECS [8] = '{
      '{lines: NSRC'(1) << 3,                                        exp_id: 32'd3},
      '{lines: (NSRC'(1) << 3) | (NSRC'(1) << 5),                    exp_id: 32'd5},
      '{lines: (NSRC'(1) << 5) | (NSRC'(1) << 70),                   exp_id: 32'd5},
      '{lines: (NSRC'(1) << 5) | (NSRC'(1) << 70) | (NSRC'(1) << 100), exp_id: 32'd100},
      '{lines: NSRC'(1) << 127,                                      exp_id: 32'd1023},
      '{lines: (NSRC'(1) << 127) | (NSRC'(1) << 3),                  exp_id: 32'd3},
      '{lines: '0,                                                   exp_id: 32'd1023},
      '{lines: (NSRC'(1) << 0) | (NSRC'(1) << 3),                    exp_id: 32'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle(input logic [NSRC-1:0] l);
      @(negedge clk);
      src_in = l;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq after reset", 32'(irq_req), 32'd0);
      rd(13'h000C, d); check("R1 ack spurious", d, 32'd1023);
      rd(13'h1400, d); check("R1 prio zero", d, 32'd0);
      rd(13'h0004, d); check("R1 threshold zero", d, 32'd0);
      rd(13'h1100, d); check("R1 enables zero", d, 32'd0);

      // configuration
      for (int w = 0; w < 4; w++) wr(13'h1100 + 13'(w * 4), 32'hFFFF_FFFF);
      for (int w = 0; w < 32; w++) wr(13'h1400 + 13'(w * 4), 32'h8080_8080);
      wr(13'h1404, 32'h8080_4080);   // src 5 = 0x40
      wr(13'h1444, 32'h8040_8080);   // src 70 = 0x40
      wr(13'h1464, 32'h8080_8010);   // src 100 = 0x10
      wr(13'h147C, 32'hA080_8080);   // src 127 = 0xA0
      wr(13'h0004, 32'h0000_0090);
      wr(13'h1000, 32'h1);
      wr(13'h0000, 32'h1);

      // table walk: R4, R5, R6, R8
      foreach (VECS[i]) begin
         settle(VECS[i].lines);
         check("R5 irq level for vector", 32'(irq_req), 32'(VECS[i].exp_id != 32'd1023));
         rd(13'h000C, d);
         check("R5/R4 winner id", d, VECS[i].exp_id);
         if (VECS[i].exp_id != 32'd1023) wr(13'h0010, VECS[i].exp_id);
      end

      // R4 raising threshold lets src 127 pass
      wr(13'h0004, 32'h0000_00A1);
      settle(NSRC'(1) << 127);
      rd(13'h000C, d); check("R4 threshold above prio", d, 32'd127);
      wr(13'h0010, 32'd127);
      wr(13'h0004, 32'h0000_0090);

      // R2 control bits gate the request
      settle(NSRC'(1) << 3);
      check("R2 request with both on", 32'(irq_req), 32'd1);
      wr(13'h0000, 32'h0);
      check("R2 cpu control off", 32'(irq_req), 32'd0);
      wr(13'h0000, 32'h1);
      wr(13'h1000, 32'h0);
      check("R2 dist control off", 32'(irq_req), 32'd0);
      wr(13'h1000, 32'h1);
      check("R2 both back on", 32'(irq_req), 32'd1);

      // R3 clear-enable indexing
      wr(13'h118C, 32'h0000_0010);   // disable src 100
      rd(13'h110C, d); check("R3 set word readback", d, 32'hFFFF_FFEF);
      rd(13'h118C, d); check("R3 clear word readback", d, 32'hFFFF_FFEF);
      settle((NSRC'(1) << 5) | (NSRC'(1) << 100));
      rd(13'h000C, d); check("R3 disabled line skipped", d, 32'd5);
      wr(13'h0010, 32'd5);
      wr(13'h110C, 32'h0000_0010);
      rd(13'h000C, d); check("R3 re-enabled line wins", d, 32'd100);

      // R7 completion handshake
      check("R7 active blocks request", 32'(irq_req), 32'd0);
      wr(13'h0010, 32'd5);
      check("R7 wrong id ignored", 32'(irq_req), 32'd0);
      rd(13'h000C, d); check("R7 ack while active", d, 32'd1023);
      wr(13'h0010, 32'd100);
      check("R7 release re-raises level", 32'(irq_req), 32'd1);

      // R8 / R11-style timing: request follows line one edge later
      @(negedge clk); src_in = '0;
      @(negedge clk);
      check("R8 level drop seen next edge", 32'(irq_req), 32'd0);
      src_in = NSRC'(1) << 3;
      check("R8 not yet registered", 32'(irq_req), 32'd0);
      @(negedge clk);
      check("R8 level rise seen next edge", 32'(irq_req), 32'd1);
      src_in = '0;
      @(negedge clk);

      // R9 edge trigger on src 40: mode word 0xC08, bit 17
      wr(13'h1C08, 32'h0002_0000);
      @(negedge clk); src_in[40] = 1'b1;
      @(negedge clk); src_in[40] = 1'b0;
      @(negedge clk);
      check("R9 edge latched after line falls", 32'(irq_req), 32'd1);
      rd(13'h000C, d); check("R9 edge claim id", d, 32'd40);
      wr(13'h0010, 32'd40);
      check("R9 pending cleared by claim", 32'(irq_req), 32'd0);
      rd(13'h000C, d); check("R9 no second claim", d, 32'd1023);

      // R10 routing bytes and mode bit 0 stored, no effect
      wr(13'h1808, 32'hA5C3_5A3C);
      rd(13'h1808, d); check("R10 routing readback", d, 32'hA5C3_5A3C);
      wr(13'h1C00, 32'h0000_0040);   // src 3 mode bit 0
      rd(13'h1C00, d); check("R10 mode readback", d, 32'h0000_0040);
      settle((NSRC'(1) << 3) | (NSRC'(1) << 8));
      rd(13'h000C, d); check("R10 arbitration unaffected", d, 32'd3);
      wr(13'h0010, 32'd3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule